// File: doc/BRIEF.md
# Mailbox Receive Status Controller

This block keeps the receive-side status of a bank of message mailboxes in a CAN controller. An upstream identifier-match stage hands it one event per accepted frame: the target mailbox index, whether the frame was a remote request or carried data, and its data length code. The block turns each event into per-mailbox flag updates. A data frame marks its mailbox as received and stores its length code. A data frame that lands on a mailbox whose earlier data has not been acknowledged still replaces that data, and the block records the overwrite. A remote request marks the mailbox as holding a pending reply request.

Software reads the flag vectors through a small register port, acknowledges bits by writing ones to them, and writes two mask registers. The block drives two level interrupt requests. The overwrite request follows a summary flag that has one enable bit. The remote request needs both a per-mailbox enable and a summary enable. The length code held in a mailbox is the reply length for a remote request, so a remote frame leaves it untouched. Software may also load that code directly.

The event input is a valid/ready stream with no back-pressure. `rx_ready` is low during reset and high in every cycle after it. Each cycle with `rx_valid` high while `rx_ready` is high delivers exactly one event, and the block never stalls the source.

Top module: `rx_status_ctrl`

## Requirements
- R1: After reset, the receive, remote-pending and overwrite vectors, the overwrite summary flag and all stored length codes are 0. Both mask registers read all ones (0xFFFFFFFF), both interrupt outputs are low, and `rx_ready` is low while `rst_n` is low.
- R2: An accepted data event (`rx_remote`=0) for mailbox n sets bit n of the receive vector (address 0) and stores `rx_dlc` as the length code of mailbox n, both visible in the cycle after the event.
- R3: An accepted data event for mailbox n whose receive bit was already 1 before the event sets bit n of the overwrite vector (address 2) and the overwrite summary flag, which is bit 9 of the flag register (address 3). The data is still stored.
- R4: An accepted remote event (`rx_remote`=1) for mailbox n sets bit n of the remote-pending vector (address 1). It leaves the receive vector, the overwrite vector and the length code of mailbox n unchanged.
- R5: Writing to address 0, 1 or 2 clears each vector bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R6: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up 1. The overwrite check still uses the receive bit as it was before that cycle.
- R7: Writing 1 to bit 9 of address 3 clears only the summary flag, not the overwrite vector. Clearing the overwrite vector does not clear the summary flag. Bit 2 of address 3 reads as 1 exactly when any remote-pending bit is 1. All other flag bits read 0.
- R8: `irq_ovr` is high exactly when the summary flag is 1 and bit 9 of the interrupt mask (address 4) is 0.
- R9: `irq_rmt` is high exactly when some mailbox n has remote-pending bit n = 1 and bit n of the mailbox mask (address 5) = 0, and also bit 2 of the interrupt mask is 0.
- R10: A write to address 32+n loads bits 3:0 of the write data as the length code of mailbox n, and a read there returns it. If a data event for mailbox n occurs in the same cycle, the event's code is stored.
- R11: `rx_ready` is high in every cycle after reset. Back-to-back events in consecutive cycles are each applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Frame-accepted event valid |
| rx_ready | output | 1 | Event accept, high after reset |
| rx_mbox | input | 5 | Target mailbox index |
| rx_remote | input | 1 | 1 = remote request, 0 = data frame |
| rx_dlc | input | 4 | Data length code of the frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_ovr | output | 1 | Overwrite interrupt request (level) |
| irq_rmt | output | 1 | Remote request interrupt (level) |

## Verification
Three actions can collide in one cycle: a frame stored into a mailbox, a software write-one-to-clear of that mailbox's receive bit, and a software length-code write to the same mailbox. The bench provokes each collision directly. It then judges two outcomes. First, the hardware result survives. Second, an overwrite is still recorded, because the receive bit was set before the cycle. Random traffic is confined to eight mailboxes with frequent register writes, so the collisions also arise by chance. Every outcome is compared against a bench model that applies the clears before the sets.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
  localparam int OVR_SUM_BIT = 9;
  localparam int RMT_SUM_BIT = 2;

  typedef enum logic [2:0] {
    RA_RXDONE  = 3'd0,
    RA_RMTPEND = 3'd1,
    RA_OVRVEC  = 3'd2,
    RA_FLAGS   = 3'd3,
    RA_IMASK   = 3'd4,
    RA_MBMASK  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/rsc_flag_vec.sv
module rsc_flag_vec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/rsc_dlc_bank.sv
module rsc_dlc_bank #(
  parameter int NUM_MB = 32,
  parameter int DLC_W  = 4,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_we,
  input  logic [IDX_W-1:0] hw_idx,
  input  logic [DLC_W-1:0] hw_dlc,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [DLC_W-1:0] sw_dlc,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DLC_W-1:0] rd_dlc
);
  logic [DLC_W-1:0] slot [NUM_MB];

  for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (hw_we && hw_idx == IDX_W'(i))
        slot[i] <= hw_dlc;
      else if (sw_we && sw_idx == IDX_W'(i))
        slot[i] <= sw_dlc;
    end
  end

  assign rd_dlc = slot[rd_idx];
endmodule

// File: rtl/rsc_irq_gate.sv
module rsc_irq_gate
  import rx_status_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int DATA_W = 32
) (
  input  logic              sum_ovr,
  input  logic [NUM_MB-1:0] rmtpend,
  input  logic [NUM_MB-1:0] mbmask,
  input  logic [DATA_W-1:0] imask,
  output logic              irq_ovr,
  output logic              irq_rmt
);
  logic any_rmt_enabled;

  always_comb begin
    any_rmt_enabled = |(rmtpend & ~mbmask);
    irq_ovr = sum_ovr && !imask[OVR_SUM_BIT];
    irq_rmt = any_rmt_enabled && !imask[RMT_SUM_BIT];
  end
endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
  import rx_status_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(NUM_MB),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [IDX_W-1:0]  rx_mbox,
  input  logic              rx_remote,
  input  logic [DLC_W-1:0]  rx_dlc,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_ovr,
  output logic              irq_rmt
);
  logic              hit, data_hit, rmt_hit, dlc_sel;
  logic [NUM_MB-1:0] mb_onehot, data_set, rmt_set, ovr_set;
  logic [NUM_MB-1:0] rxdone_q, rmtpend_q, ovrvec_q;
  logic [NUM_MB-1:0] rxdone_clr, rmtpend_clr, ovrvec_clr;
  logic [NUM_MB-1:0] mbmask_q;
  logic [DATA_W-1:0] imask_q;
  logic              sum_ovr_q;
  logic [DLC_W-1:0]  dlc_rd;
  reg_sel_e          sel;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_ready <= 1'b0;
    else        rx_ready <= 1'b1;
  end

  assign hit       = rx_valid && rx_ready;
  assign data_hit  = hit && !rx_remote;
  assign rmt_hit   = hit && rx_remote;
  assign mb_onehot = NUM_MB'(1) << rx_mbox;
  assign data_set  = data_hit ? mb_onehot : '0;
  assign rmt_set   = rmt_hit  ? mb_onehot : '0;
  assign ovr_set   = data_set & rxdone_q;

  assign dlc_sel = reg_addr[IDX_W];
  assign sel     = reg_sel_e'(reg_addr[2:0]);

  always_comb begin
    rxdone_clr  = '0;
    rmtpend_clr = '0;
    ovrvec_clr  = '0;
    if (reg_wr && !dlc_sel && reg_addr[IDX_W-1:3] == '0) begin
      case (sel)
        RA_RXDONE:  rxdone_clr  = reg_wdata[NUM_MB-1:0];
        RA_RMTPEND: rmtpend_clr = reg_wdata[NUM_MB-1:0];
        RA_OVRVEC:  ovrvec_clr  = reg_wdata[NUM_MB-1:0];
        default: ;
      endcase
    end
  end

  rsc_flag_vec #(.W(NUM_MB)) i_rxdone (
    .clk(clk), .rst_n(rst_n), .set_i(data_set), .clr_i(rxdone_clr), .q_o(rxdone_q));
  rsc_flag_vec #(.W(NUM_MB)) i_rmtpend (
    .clk(clk), .rst_n(rst_n), .set_i(rmt_set), .clr_i(rmtpend_clr), .q_o(rmtpend_q));
  rsc_flag_vec #(.W(NUM_MB)) i_ovrvec (
    .clk(clk), .rst_n(rst_n), .set_i(ovr_set), .clr_i(ovrvec_clr), .q_o(ovrvec_q));

  logic reg_low_wr;
  assign reg_low_wr = reg_wr && !dlc_sel && reg_addr[IDX_W-1:3] == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_ovr_q <= 1'b0;
      imask_q   <= '1;
      mbmask_q  <= '1;
    end else begin
      if (|ovr_set)
        sum_ovr_q <= 1'b1;
      else if (reg_low_wr && sel == RA_FLAGS && reg_wdata[OVR_SUM_BIT])
        sum_ovr_q <= 1'b0;
      if (reg_low_wr && sel == RA_IMASK)
        imask_q <= reg_wdata;
      if (reg_low_wr && sel == RA_MBMASK)
        mbmask_q <= reg_wdata[NUM_MB-1:0];
    end
  end

  rsc_dlc_bank #(.NUM_MB(NUM_MB), .DLC_W(DLC_W)) i_dlc (
    .clk(clk), .rst_n(rst_n),
    .hw_we(data_hit), .hw_idx(rx_mbox), .hw_dlc(rx_dlc),
    .sw_we(reg_wr && dlc_sel), .sw_idx(reg_addr[IDX_W-1:0]),
    .sw_dlc(reg_wdata[DLC_W-1:0]),
    .rd_idx(reg_addr[IDX_W-1:0]), .rd_dlc(dlc_rd));

  rsc_irq_gate #(.NUM_MB(NUM_MB), .DATA_W(DATA_W)) i_irq (
    .sum_ovr(sum_ovr_q), .rmtpend(rmtpend_q), .mbmask(mbmask_q), .imask(imask_q),
    .irq_ovr(irq_ovr), .irq_rmt(irq_rmt));

  always_comb begin
    reg_rdata = '0;
    if (dlc_sel) begin
      reg_rdata = DATA_W'(dlc_rd);
    end else if (reg_addr[IDX_W-1:3] == '0) begin
      case (sel)
        RA_RXDONE:  reg_rdata = DATA_W'(rxdone_q);
        RA_RMTPEND: reg_rdata = DATA_W'(rmtpend_q);
        RA_OVRVEC:  reg_rdata = DATA_W'(ovrvec_q);
        RA_FLAGS: begin
          reg_rdata[OVR_SUM_BIT] = sum_ovr_q;
          reg_rdata[RMT_SUM_BIT] = |rmtpend_q;
        end
        RA_IMASK:   reg_rdata = imask_q;
        RA_MBMASK:  reg_rdata = DATA_W'(mbmask_q);
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rx_status_chk.sv
module rx_status_chk
  import rx_status_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [IDX_W-1:0]  rx_mbox,
  input logic              rx_remote,
  input logic [NUM_MB-1:0] rxdone,
  input logic [NUM_MB-1:0] rmtpend,
  input logic [NUM_MB-1:0] ovrvec,
  input logic              sum_ovr,
  input logic [DATA_W-1:0] imask,
  input logic [NUM_MB-1:0] mbmask,
  input logic              irq_ovr,
  input logic              irq_rmt
);
  // R2
  rx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !rx_remote |=> rxdone[$past(rx_mbox)]);

  // R3
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !rx_remote && rxdone[rx_mbox]
    |=> ovrvec[$past(rx_mbox)] && sum_ovr);

  // R4
  rmt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && rx_remote |=> rmtpend[$past(rx_mbox)]);

  // R8
  ovr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr |-> sum_ovr && !imask[OVR_SUM_BIT]);

  // R9
  rmt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rmt |-> !imask[RMT_SUM_BIT] && |(rmtpend & ~mbmask));

  // R11
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rx_ready);
endmodule

bind rx_status_ctrl rx_status_chk #(.NUM_MB(NUM_MB), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_mbox(rx_mbox), .rx_remote(rx_remote), .rxdone(rxdone_q),
  .rmtpend(rmtpend_q), .ovrvec(ovrvec_q), .sum_ovr(sum_ovr_q),
  .imask(imask_q), .mbmask(mbmask_q), .irq_ovr(irq_ovr), .irq_rmt(irq_rmt));

// File: tb/test_rx_status_ctrl.sv
module test_rx_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_remote = 1'b0, reg_wr = 1'b0;
  logic        rx_ready, irq_ovr, irq_rmt;
  logic [4:0]  rx_mbox = '0;
  logic [3:0]  rx_dlc = '0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] m_done, m_rmt, m_ovr, m_imask, m_mbm;
  logic        m_sum;
  logic [3:0]  m_dlc [32];

  always #10 clk = ~clk;

  rx_status_ctrl i_rx_status_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_mbox(rx_mbox), .rx_remote(rx_remote), .rx_dlc(rx_dlc),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ovr(irq_ovr), .irq_rmt(irq_rmt));

  function automatic logic [31:0] exp_reg(input logic [5:0] a);
    if (a[5]) return {28'd0, m_dlc[a[4:0]]};
    case (a)
      6'd0: return m_done;
      6'd1: return m_rmt;
      6'd2: return m_ovr;
      6'd3: return (32'(m_sum) << 9) | (32'(|m_rmt) << 2);
      6'd4: return m_imask;
      6'd5: return m_mbm;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq_ovr();
    return m_sum && !m_imask[9];
  endfunction

  function automatic logic exp_irq_rmt();
    return (|(m_rmt & ~m_mbm)) && !m_imask[2];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_done = '0; m_rmt = '0; m_ovr = '0; m_sum = 1'b0;
    m_imask = '1; m_mbm = '1;
    for (int i = 0; i < 32; i++) m_dlc[i] = '0;
  endtask

  // one clock: apply inputs, update model (clears first, then sets), check irqs
  task automatic step(input logic v, input logic [4:0] mb, input logic rm,
                      input logic [3:0] dl, input logic wr, input logic [5:0] a,
                      input logic [31:0] wd);
    logic [31:0] clr_d, clr_r, clr_o;
    logic        old_done_bit;
    rx_valid = v; rx_mbox = mb; rx_remote = rm; rx_dlc = dl;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    clr_d = (wr && a == 6'd0) ? wd : '0;
    clr_r = (wr && a == 6'd1) ? wd : '0;
    clr_o = (wr && a == 6'd2) ? wd : '0;
    old_done_bit = m_done[mb];
    m_done = m_done & ~clr_d;
    m_rmt  = m_rmt & ~clr_r;
    m_ovr  = m_ovr & ~clr_o;
    if (wr && a == 6'd3 && wd[9]) m_sum = 1'b0;
    if (wr && a == 6'd4) m_imask = wd;
    if (wr && a == 6'd5) m_mbm = wd;
    if (wr && a[5]) m_dlc[a[4:0]] = wd[3:0];
    if (v && !rm) begin
      if (old_done_bit) begin m_ovr[mb] = 1'b1; m_sum = 1'b1; end
      m_done[mb] = 1'b1;
      m_dlc[mb] = dl;
    end
    if (v && rm) m_rmt[mb] = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; reg_wr = 1'b0;
    check("R8 irq_ovr", 32'(irq_ovr), 32'(exp_irq_ovr()));
    check("R9 irq_rmt", 32'(irq_rmt), 32'(exp_irq_rmt()));
  endtask

  task automatic rd(input string req, input logic [5:0] a);
    rx_valid = 1'b0; reg_wr = 1'b0; reg_addr = a;
    #2;
    check(req, reg_rdata, exp_reg(a));
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 6; a++) rd(req, 6'(a));
    for (int i = 0; i < 8; i++) rd(req, 6'(32 + i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state and no ready during reset
    check("R1 ready in reset", 32'(rx_ready), 32'd0);
    check("R1 irq_ovr reset", 32'(irq_ovr), 32'd0);
    check("R1 irq_rmt reset", 32'(irq_rmt), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 ready after reset
    check("R11 ready", 32'(rx_ready), 32'd1);
    check_all("R1 reset regs");

    // R2 data store, R11 back-to-back events
    step(1, 5'd3, 0, 4'd6, 0, 0, 0);
    step(1, 5'd4, 0, 4'd2, 0, 0, 0);
    rd("R2 rxdone", 6'd0);
    rd("R2 dlc", 6'd35);
    rd("R11 second event", 6'd36);
    // R6 same-cycle store and clear of mailbox 3: stays set, overwrite recorded
    step(1, 5'd3, 0, 4'd9, 1, 6'd0, 32'h8);
    rd("R6 rxdone survives clear", 6'd0);
    rd("R3 R6 overwrite vector", 6'd2);
    rd("R3 summary flag", 6'd3);
    // R8 enable overwrite irq
    step(0, 0, 0, 0, 1, 6'd4, 32'hFFFF_FDFF);
    check("R8 irq_ovr enabled", 32'(irq_ovr), 32'd1);
    // R7 clear summary, vector stays
    step(0, 0, 0, 0, 1, 6'd3, 32'h200);
    rd("R7 vector kept", 6'd2);
    rd("R7 summary cleared", 6'd3);
    // R5 write-0 bits untouched, write-1 clears
    step(0, 0, 0, 0, 1, 6'd0, 32'h10);
    rd("R5 w1c rxdone", 6'd0);
    // R4 remote keeps software-loaded length code
    step(0, 0, 0, 0, 1, 6'd37, 32'h7);
    step(1, 5'd5, 1, 4'd0, 0, 0, 0);
    rd("R4 dlc kept", 6'd37);
    rd("R4 rxdone unchanged", 6'd0);
    rd("R4 rmtpend", 6'd1);
    rd("R7 rmt summary", 6'd3);
    // R9 two-level gating
    step(0, 0, 0, 0, 1, 6'd5, ~32'h20);
    check("R9 summary mask off", 32'(irq_rmt), 32'd0);
    step(0, 0, 0, 0, 1, 6'd4, 32'hFFFF_FDFB);
    check("R9 both enabled", 32'(irq_rmt), 32'd1);
    // R10 same-cycle hw and sw length write: hw wins
    step(1, 5'd6, 0, 4'd11, 1, 6'd38, 32'h1);
    rd("R10 hw wins", 6'd38);
    step(0, 0, 0, 0, 1, 6'd38, 32'h4);
    rd("R10 sw write", 6'd38);
    check_all("R1..R10 directed");

    // random traffic on 8 mailboxes
    for (int n = 0; n < 1500; n++) begin
      logic [5:0] a;
      int r;
      r = int'($urandom % 8);
      a = (r < 6) ? 6'(r) : 6'(32 + ($urandom % 8));
      step(($urandom % 2) == 0, 5'($urandom % 8), ($urandom % 4) == 0,
           4'($urandom), ($urandom % 3) == 0, a, $urandom);
      if (n % 100 == 99) check_all("R2..R10 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule